// File: doc/BRIEF.md
# HDM decoder target lookup

This block resolves a host physical address to a downstream port number by walking a bank of host-managed device memory decoders. Each decoder owns a window (base and size, both aligned to 256 MiB), a control word with a committed flag and two interleave codes, and an eight-entry target list packed into two 32-bit words. A capability word sets how many decoders take part in the search.

Software-side programming is modelled as a plain register write port. A lookup starts with a one-cycle start pulse. The block then examines one decoder per clock, in ascending index order. The first decoder whose window contains the address ends the scan. A one-cycle done pulse returns the hit flag and the selected port byte. The scan never exceeds the decoded decoder count, so the latency is bounded.

Top module: `hdm_target_lookup`

## Requirements
- R1: A decoder's base is {base_hi word, base_lo[31:28], 28 zero bits}. Its size is formed the same way from the size words. Bits 27:0 of either low word have no effect on matching.
- R2: A decoder matches when base <= address < base + size. Decoders are examined from index 0 upward, and the first match ends the scan.
- R3: When the first matching decoder has its committed bit (control bit 10) clear, the lookup ends as a miss and later decoders are not consulted.
- R4: The interleave index is (address >> (8 + G)) mod 2^W, where G is control bits 3:0 and W is control bits 7:4. W codes above 3 act as 3.
- R5: Index 0..3 selects byte 0..3 (byte 0 = bits 7:0) of the low target word. Index 4..7 selects byte 0..3 of the high target word. The selected byte is the reported port.
- R6: The capability count code (capability bits 3:0) decodes as follows: 0 gives 1 decoder, n gives 2n decoders, and the result is capped at MAX_DEC (10). Decoders at or above the decoded count are never matched.
- R7: When no scanned decoder matches, the result is a miss. On any miss, port_o reads 0.
- R8: Let the start be sampled at edge 0, and let k be the index of the decoder that ends the scan (the match, or the last scanned decoder). Then done_o is high for exactly one cycle, following edge k+1. hit_o and port_o change only together with done_o and hold their values otherwise.
- R9: A start pulse during a scan is ignored. The running scan keeps its captured address and finishes with its own result and timing.
- R10: The write select codes are: 0 base low, 1 base high, 2 size low, 3 size high, 4 control, 5 target low, 6 target high, and 7 capability (decoder index ignored). A write with an index at or above MAX_DEC is dropped.
- R11: After reset, done_o, hit_o and port_o are 0 and all registers are zero. A lookup on the reset state therefore scans one empty decoder and misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select (R10) |
| wr_idx_i | input | IDX_W (4) | Decoder index for the write |
| wr_data_i | input | 32 | Write data |
| start_i | input | 1 | Lookup start pulse |
| addr_i | input | 64 | Host physical address, captured at start |
| done_o | output | 1 | Lookup complete pulse |
| hit_o | output | 1 | Lookup found a committed decoder |
| port_o | output | 8 | Selected downstream port number |

## Verification
A new start request can arrive in the same cycles as an active scan, and in the very cycle the scan raises done. The bench fires a second start with a different address three cycles into a long scan that ends at decoder 9. It then checks three things: the done pulse comes at the latency of the first address, the port comes from the first address's decoder, and no second done follows. The checker also requires that the captured address stays stable whenever a start arrives while busy.

// File: rtl/hdm_pkg.sv
package hdm_pkg;
  localparam int WORD_W    = 32;
  localparam int PORT_W    = WORD_W / 4;
  localparam int ALIGN_LSB = 28;
  localparam int GRAN_SH   = 8;
  localparam int IG_LSB    = 0;
  localparam int IW_LSB    = 4;
  localparam int CODE_W    = 4;
  localparam int COMMIT_B  = 10;
  localparam int IW_MAX    = 3;

  typedef enum logic [2:0] {
    SEL_BASE_LO = 3'd0,
    SEL_BASE_HI = 3'd1,
    SEL_SIZE_LO = 3'd2,
    SEL_SIZE_HI = 3'd3,
    SEL_CTRL    = 3'd4,
    SEL_TGT_LO  = 3'd5,
    SEL_TGT_HI  = 3'd6,
    SEL_CAP     = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [WORD_W-1:0] base_lo;
    logic [WORD_W-1:0] base_hi;
    logic [WORD_W-1:0] size_lo;
    logic [WORD_W-1:0] size_hi;
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] tgt_lo;
    logic [WORD_W-1:0] tgt_hi;
  } dec_regs_t;
endpackage

// File: rtl/hdm_regs.sv
module hdm_regs
  import hdm_pkg::*;
#(
  parameter int N_DEC = 10,
  parameter int IDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output dec_regs_t         dec_o [N_DEC],
  output logic [WORD_W-1:0] cap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_o <= '0;
    else if (wr_en_i && wr_sel_i == SEL_CAP) cap_o <= wr_data_i;
  end

  for (genvar g = 0; g < N_DEC; g++) begin : g_dec
    logic sel_this;
    assign sel_this = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dec_o[g] <= '0;
      else if (sel_this) begin
        unique case (wr_sel_i)
          SEL_BASE_LO: dec_o[g].base_lo <= wr_data_i;
          SEL_BASE_HI: dec_o[g].base_hi <= wr_data_i;
          SEL_SIZE_LO: dec_o[g].size_lo <= wr_data_i;
          SEL_SIZE_HI: dec_o[g].size_hi <= wr_data_i;
          SEL_CTRL:    dec_o[g].ctrl    <= wr_data_i;
          SEL_TGT_LO:  dec_o[g].tgt_lo  <= wr_data_i;
          SEL_TGT_HI:  dec_o[g].tgt_hi  <= wr_data_i;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hdm_match.sv
module hdm_match
  import hdm_pkg::*;
#(
  parameter int ADDR_W = 2 * WORD_W
) (
  input  dec_regs_t         dec_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_range_o,
  output logic              committed_o,
  output logic [PORT_W-1:0] port_o
);
  localparam int HI_W = WORD_W - ALIGN_LSB;

  logic [ADDR_W-1:0] base, size, shifted;
  logic [ADDR_W:0]   limit;
  logic [CODE_W-1:0] ig, iw, iw_c;
  logic [2:0]        mask, idx;
  logic [WORD_W-1:0] word;

  assign base  = {dec_i.base_hi, dec_i.base_lo[WORD_W-1 -: HI_W], {ALIGN_LSB{1'b0}}};
  assign size  = {dec_i.size_hi, dec_i.size_lo[WORD_W-1 -: HI_W], {ALIGN_LSB{1'b0}}};
  assign limit = {1'b0, base} + {1'b0, size};
  assign in_range_o  = (addr_i >= base) && ({1'b0, addr_i} < limit);
  assign committed_o = dec_i.ctrl[COMMIT_B];

  assign ig   = dec_i.ctrl[IG_LSB +: CODE_W];
  assign iw   = dec_i.ctrl[IW_LSB +: CODE_W];
  assign iw_c = (iw > CODE_W'(IW_MAX)) ? CODE_W'(IW_MAX) : iw;
  assign shifted = addr_i >> (GRAN_SH + int'(ig));
  assign mask = 3'((4'd1 << iw_c) - 4'd1);
  assign idx  = shifted[2:0] & mask;
  assign word = idx[2] ? dec_i.tgt_hi : dec_i.tgt_lo;
  assign port_o = word[{idx[1:0], 3'b000} +: PORT_W];

  logic unused_bits;
  assign unused_bits = ^{dec_i.base_lo[ALIGN_LSB-1:0], dec_i.size_lo[ALIGN_LSB-1:0],
                         dec_i.ctrl[WORD_W-1:COMMIT_B+1], dec_i.ctrl[COMMIT_B-1:IW_LSB+CODE_W],
                         shifted[ADDR_W-1:3]};
endmodule

// File: rtl/hdm_scan.sv
module hdm_scan
  import hdm_pkg::*;
#(
  parameter int MAX_DEC = 10,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] cap_code_i,
  input  logic              in_range_i,
  input  logic              committed_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              busy_o,
  output logic              load_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [PORT_W-1:0] port_o
);
  typedef enum logic {ST_IDLE, ST_SCAN} state_e;
  state_e state_q;
  logic   last;

  always_comb begin
    if (cap_code_i == '0)                 count_o = CNT_W'(1);
    else if (int'(cap_code_i) >= MAX_DEC / 2) count_o = CNT_W'(MAX_DEC);
    else                                  count_o = CNT_W'(2 * int'(cap_code_i));
  end

  assign busy_o = (state_q == ST_SCAN);
  assign load_o = start_i && !busy_o;
  assign last   = (CNT_W'(idx_o) + CNT_W'(1)) == count_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_o   <= '0;
      done_o  <= 1'b0;
      hit_o   <= 1'b0;
      port_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        state_q <= ST_SCAN;
        idx_o   <= '0;
      end else if (busy_o) begin
        if (in_range_i) begin
          // first window wins, committed or not
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          hit_o   <= committed_i;
          port_o  <= committed_i ? port_i : '0;
        end else if (last) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          hit_o   <= 1'b0;
          port_o  <= '0;
        end else begin
          idx_o <= idx_o + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/hdm_target_lookup.sv
module hdm_target_lookup
  import hdm_pkg::*;
#(
  parameter int  MAX_DEC = 10,
  localparam int IDX_W   = $clog2(MAX_DEC),
  localparam int CNT_W   = $clog2(MAX_DEC + 1),
  localparam int ADDR_W  = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              done_o,
  output logic              hit_o,
  output logic [PORT_W-1:0] port_o
);
  dec_regs_t         dec_q [MAX_DEC];
  dec_regs_t         cur;
  logic [WORD_W-1:0] cap_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  scan_idx;
  logic [CNT_W-1:0]  dec_count;
  logic              busy, load, in_range, committed;
  logic [PORT_W-1:0] cand_port;

  hdm_regs #(.N_DEC(MAX_DEC), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_idx_i, .wr_data_i,
    .dec_o(dec_q), .cap_o(cap_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= '0;
    else if (load) addr_q <= addr_i;
  end

  always_comb begin
    cur = dec_q[0];
    for (int i = 1; i < MAX_DEC; i++)
      if (scan_idx == IDX_W'(i)) cur = dec_q[i];
  end

  hdm_match #(.ADDR_W(ADDR_W)) u_match (
    .dec_i(cur), .addr_i(addr_q),
    .in_range_o(in_range), .committed_o(committed), .port_o(cand_port)
  );

  hdm_scan #(.MAX_DEC(MAX_DEC), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_scan (
    .clk_i, .rst_ni, .start_i,
    .cap_code_i(cap_q[CODE_W-1:0]),
    .in_range_i(in_range), .committed_i(committed), .port_i(cand_port),
    .busy_o(busy), .load_o(load), .idx_o(scan_idx), .count_o(dec_count),
    .done_o, .hit_o, .port_o
  );

  logic unused_cap;
  assign unused_cap = ^cap_q[WORD_W-1:CODE_W];
endmodule

// File: rtl/hdm_lookup_chk.sv
module hdm_lookup_chk #(
  parameter int MAX_DEC = 10,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 4,
  parameter int ADDR_W  = 64,
  parameter int PORT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy,
  input logic [IDX_W-1:0]  scan_idx,
  input logic [CNT_W-1:0]  dec_count,
  input logic [ADDR_W-1:0] addr_q,
  input logic              done_o,
  input logic              hit_o,
  input logic [PORT_W-1:0] port_o
);
  logic [CNT_W:0] cyc_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cyc_cnt <= '0;
    else if (start_i && !busy)   cyc_cnt <= '0;
    else if (busy && cyc_cnt != '1) cyc_cnt <= cyc_cnt + 1'b1;
  end

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(hit_o) && $stable(port_o)));
  a_r7_miss_port_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (port_o == '0));
  a_r9_addr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> $stable(addr_q));
  a_r6_idx_in_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> ((CNT_W)'(scan_idx) < dec_count));
  a_r8_bounded_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (cyc_cnt < (CNT_W+1)'(MAX_DEC)));
endmodule

bind hdm_target_lookup hdm_lookup_chk #(
  .MAX_DEC(MAX_DEC), .IDX_W(IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .PORT_W(hdm_pkg::PORT_W)
) u_chk (
  .clk_i, .rst_ni, .start_i, .busy, .scan_idx, .dec_count, .addr_q,
  .done_o, .hit_o, .port_o
);

// File: tb/hdm_target_lookup_tb.sv
module hdm_target_lookup_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [3:0]  wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        start_i = 1'b0;
  logic [63:0] addr_i = '0;
  logic        done_o, hit_o;
  logic [7:0]  port_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  hdm_target_lookup u_dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int idx, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 3'(sel); wr_idx_i = 4'(idx); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic prog(input int idx, input logic [63:0] base, input logic [63:0] size,
                      input logic [31:0] ctrl, input logic [31:0] tlo, input logic [31:0] thi);
    wr(0, idx, base[31:0]); wr(1, idx, base[63:32]);
    wr(2, idx, size[31:0]); wr(3, idx, size[63:32]);
    wr(4, idx, ctrl); wr(5, idx, tlo); wr(6, idx, thi);
  endtask

  // latency counted in negedges after the start edge: scan ending at decoder k gives k+1
  task automatic lookup(input logic [63:0] a, input bit e_hit, input logic [7:0] e_port,
                        input int e_lat, input string req);
    int lat;
    logic h; logic [7:0] p;
    @(negedge clk_i);
    addr_i = a; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 60) begin @(negedge clk_i); lat++; end
    check(lat == e_lat, req, "latency", lat, e_lat);
    check(hit_o == e_hit, req, "hit", hit_o, e_hit);
    check(port_o == e_port, req, "port", port_o, e_port);
    h = hit_o; p = port_o;
    @(negedge clk_i);
    check(!done_o && hit_o == h && port_o == p, "R8", "done pulse/hold",
          {done_o, hit_o, port_o}, {1'b0, h, p});
  endtask

  task automatic t_reset;
    check(!done_o && !hit_o && port_o == 0, "R11", "reset outputs",
          {done_o, hit_o, port_o}, 0);
    lookup(64'h0, 0, 0, 1, "R11");
  endtask

  task automatic t_program;
    wr(7, 0, 32'h2); // four decoders
    prog(0, 64'h1_0000_0000, 64'h1000_0000, 32'h400, 32'h4433_2211, 32'h0);
    wr(0, 1, 32'h2FFF_FFFF); wr(1, 1, 32'h1);
    wr(2, 1, 32'h2ABC_DEF0); wr(3, 1, 32'h0);
    wr(4, 1, 32'h431); wr(5, 1, 32'hD3C2_B1A0); wr(6, 1, 32'hE7E6_E5E4);
    prog(2, 64'h1_4000_0000, 64'h1000_0000, 32'h000, 32'h55, 32'h0);
    prog(3, 64'h1_4000_0000, 64'h1000_0000, 32'h400, 32'h66, 32'h0);
    prog(9, 64'h9_0000_0000, 64'h1000_0000, 32'h400, 32'h77, 32'h0);
    wr(0, 12, 32'hFFFF_FFFF); // index out of range, dropped (R10)
  endtask

  task automatic t_range;
    lookup(64'h1_0000_0000, 1, 8'h11, 1, "R2");
    lookup(64'h1_0FFF_FFFF, 1, 8'h11, 1, "R2");
    lookup(64'h1_1000_0000, 0, 8'h00, 4, "R2");
  endtask

  task automatic t_align_interleave;
    lookup(64'h1_2000_0000, 1, 8'hA0, 2, "R1");
    lookup(64'h1_3FFF_FE00, 1, 8'hE7, 2, "R1");
    lookup(64'h1_2000_0A00, 1, 8'hE5, 2, "R5");
    lookup(64'h1_2000_0400, 1, 8'hC2, 2, "R4");
    wr(4, 1, 32'h471); // ways code 7 acts as 3
    lookup(64'h1_2000_0A00, 1, 8'hE5, 2, "R4");
  endtask

  task automatic t_uncommitted;
    lookup(64'h1_4000_0100, 0, 8'h00, 3, "R3");
  endtask

  task automatic t_nomatch;
    lookup(64'h5, 0, 8'h00, 4, "R7");
  endtask

  task automatic t_count;
    wr(7, 0, 32'h0);
    lookup(64'h1_2000_0000, 0, 8'h00, 1, "R6");
    wr(7, 0, 32'h1);
    lookup(64'h1_2000_0000, 1, 8'hA0, 2, "R6");
    lookup(64'h1_4000_0000, 0, 8'h00, 2, "R6");
    wr(7, 0, 32'h5);
    lookup(64'h9_0000_0000, 1, 8'h77, 10, "R6");
    wr(7, 0, 32'hF);
    lookup(64'h9_0000_0000, 1, 8'h77, 10, "R10");
  endtask

  task automatic t_start_busy;
    int lat, extra;
    @(negedge clk_i);
    addr_i = 64'h9_0000_0000; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 60) begin
      @(negedge clk_i); lat++;
      start_i = (lat == 3);
      if (lat == 3) addr_i = 64'h1_0000_0000;
    end
    start_i = 1'b0;
    check(lat == 10, "R9", "latency with extra start", lat, 10);
    check(hit_o && port_o == 8'h77, "R9", "result of first address", port_o, 8'h77);
    extra = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk_i); if (done_o) extra++; end
    check(extra == 0, "R9", "spurious done count", extra, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_program();
    t_range();
    t_align_interleave();
    t_uncommitted();
    t_nomatch();
    t_count();
    t_start_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule